// File: doc/BRIEF.md
# System-Management Interrupt Flag Aggregator

This block collects system-management interrupt requests from a set of sources and presents them as one device-level request line. Every source owns a software-writable enable bit and a sticky flag bit. A flag is set by a rising edge of the source's event as seen through its enable. Handler software clears a flag by writing a one to it.

Sources come in two kinds, chosen per index by parameters. The low `N_DIR` sources are direct: each takes an asynchronous event pulse that may be far shorter than a clock period. That pulse is caught by an asynchronously set stretcher and then passed through a synchronizer. The remaining sources are indirect. Each one watches a summary level, which is the OR of a parameter-selected group of native event status bits. Every status bit is set by its own native event input and cleared by its own write-one-to-clear. Status and flag clear independently of each other.

Because only rising edges set a flag, a summary that stays high after its flag is cleared does not set the flag again. Handler software can deliberately re-arm the flag by writing the enable low and then high again while the summary is still high.

Top module: `smi_flag_aggregator`

## Requirements
- R1: After reset, every enable, flag and status bit reads 0 and `smi_o` is low.
- R2: Address 0 holds the enables, bit i for source i. A write stores `reg_wdata` there, and a read returns the stored value. Address 3 reads as 0.
- R3: Address 1 holds the flags, bit i for source i. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R4: A direct-source event pulse narrower than one clock period, arriving while that source is enabled, sets its flag within 5 clock cycles.
- R5: A direct-source pulse that arrives while the enable is 0 sets no flag, and enabling the source afterwards does not set the flag either.
- R6: If the flag of an indirect source is cleared while its summary level stays high, the flag stays clear.
- R7: With the summary level still high, writing the enable to 0 and then back to 1 sets the flag again.
- R8: Address 2 holds the native status bits, bit j for native event input j. A high native event input sets its status bit, and writing 1 to the bit clears it. Indirect source N_DIR+k watches the OR of the status bits selected by `SUM_MAP[k*N_SRC +: N_SRC]`. With the defaults, source 4 watches bit 7, source 5 watches bit 6, source 6 watches bits 5 and 4, and source 7 watches bits 3 to 0.
- R9: Clearing a native status bit never changes any flag.
- R10: When a set edge and a write-one-to-clear reach the same flag in the same cycle, the flag ends up set.
- R11: `smi_o` is high exactly when at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_DIR | Asynchronous event pulses of the direct sources |
| nat_evt_i | input | N_SRC | Synchronous native event inputs that set the status bits |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 enables, 1 flags, 2 status |
| reg_wdata | input | N_SRC | Write data |
| reg_rdata | output | N_SRC | Read data of the selected register (combinational) |
| smi_o | output | 1 | Device-level interrupt request, the OR of all flags |

## Verification
The direct path is driven with a 1 ns pulse placed between clock edges. It is tried once with its source enabled and once with the source disabled, which distinguishes a captured sub-cycle pulse from a pulse that has gone stale. The indirect path is driven with a summary held high across a flag clear and then across an enable toggle, which separates a level-sensitive flag from an edge-sensitive flag that can be re-armed. Native events are placed on different status bits to confirm that each bit reaches only the source named in the summary map. A set edge is arranged to land in the same cycle as a clearing write, which reveals the priority between the two.

// File: rtl/smi_agg_pkg.sv
package smi_agg_pkg;

   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      SEL_ENABLE = 2'd0,
      SEL_FLAG   = 2'd1,
      SEL_STATUS = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/smi_edge_det.sv
module smi_edge_det #(
   parameter bit          ASYNC_CAPTURE = 1'b1,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic en,
   output logic rise
);

   logic gated;
   logic armed_q;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("smi_edge_det: SYNC_STAGES must be at least 2");
   end

   if (ASYNC_CAPTURE) begin : g_async
      logic                   stretch_q;
      logic [SYNC_STAGES-1:0] sync_q;

      // stretcher: set by the raw pulse, dropped once the synchronizer has it
      always_ff @(posedge clk or posedge lvl or negedge rst_n) begin
         if (!rst_n) begin
            stretch_q <= 1'b0;
         end else if (lvl) begin
            stretch_q <= 1'b1;
         end else if (sync_q[SYNC_STAGES-1]) begin
            stretch_q <= 1'b0;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q <= '0;
         end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], stretch_q};
         end
      end

      assign gated = sync_q[SYNC_STAGES-1] & en;
   end else begin : g_level
      assign gated = lvl & en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else begin
         armed_q <= gated;
      end
   end

   assign rise = gated & ~armed_q;

endmodule

// File: rtl/smi_regs.sv
module smi_regs
   import smi_agg_pkg::*;
#(
   parameter int unsigned N_SRC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [N_SRC-1:0]  wdata,
   input  logic [N_SRC-1:0]  flag_set,
   input  logic [N_SRC-1:0]  nat_set,
   output logic [N_SRC-1:0]  en_q,
   output logic [N_SRC-1:0]  flag_q,
   output logic [N_SRC-1:0]  stat_q,
   output logic [N_SRC-1:0]  rdata
);

   logic [N_SRC-1:0] flag_clr;
   logic [N_SRC-1:0] stat_clr;

   assign flag_clr = (we && addr == SEL_FLAG)   ? wdata : '0;
   assign stat_clr = (we && addr == SEL_STATUS) ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         flag_q <= '0;
         stat_q <= '0;
      end else begin
         if (we && addr == SEL_ENABLE) begin
            en_q <= wdata;
         end
         // set terms are ORed after the clear mask so an arriving edge survives
         flag_q <= (flag_q & ~flag_clr) | flag_set;
         stat_q <= (stat_q & ~stat_clr) | nat_set;
      end
   end

   always_comb begin
      case (addr)
         SEL_ENABLE: rdata = en_q;
         SEL_FLAG:   rdata = flag_q;
         SEL_STATUS: rdata = stat_q;
         default:    rdata = '0;
      endcase
   end

endmodule

// File: rtl/smi_flag_aggregator.sv
module smi_flag_aggregator
   import smi_agg_pkg::*;
#(
   parameter int unsigned N_SRC       = 8,
   parameter int unsigned N_DIR       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [(N_SRC-N_DIR)*N_SRC-1:0] SUM_MAP = 32'h0F30_4080
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_DIR-1:0]  evt_i,
   input  logic [N_SRC-1:0]  nat_evt_i,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [N_SRC-1:0]  reg_wdata,
   output logic [N_SRC-1:0]  reg_rdata,
   output logic              smi_o
);

   localparam int unsigned N_IND = N_SRC - N_DIR;

   if (N_DIR < 1 || N_DIR >= N_SRC) begin : g_bad_split
      $error("smi_flag_aggregator: need 1 <= N_DIR < N_SRC");
   end

   logic [N_SRC-1:0] en_w;
   logic [N_SRC-1:0] flag_w;
   logic [N_SRC-1:0] stat_w;
   logic [N_SRC-1:0] set_w;

   for (genvar i = 0; i < N_DIR; i++) begin : g_direct
      smi_edge_det #(
         .ASYNC_CAPTURE(1'b1),
         .SYNC_STAGES  (SYNC_STAGES)
      ) u_edge (
         .clk  (clk),
         .rst_n(rst_n),
         .lvl  (evt_i[i]),
         .en   (en_w[i]),
         .rise (set_w[i])
      );
   end

   for (genvar k = 0; k < N_IND; k++) begin : g_indirect
      logic summary;
      assign summary = |(stat_w & SUM_MAP[k*N_SRC +: N_SRC]);

      smi_edge_det #(
         .ASYNC_CAPTURE(1'b0),
         .SYNC_STAGES  (SYNC_STAGES)
      ) u_edge (
         .clk  (clk),
         .rst_n(rst_n),
         .lvl  (summary),
         .en   (en_w[N_DIR+k]),
         .rise (set_w[N_DIR+k])
      );
   end

   smi_regs #(
      .N_SRC(N_SRC)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .flag_set(set_w),
      .nat_set (nat_evt_i),
      .en_q    (en_w),
      .flag_q  (flag_w),
      .stat_q  (stat_w),
      .rdata   (reg_rdata)
   );

   assign smi_o = |flag_w;

endmodule

// File: rtl/smi_flag_aggregator_chk.sv
module smi_flag_aggregator_chk
   import smi_agg_pkg::*;
#(
   parameter int unsigned N_SRC = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [N_SRC-1:0]  reg_wdata,
   input logic [N_SRC-1:0]  flag,
   input logic [N_SRC-1:0]  set_pulse,
   input logic              smi_o
);

   for (genvar i = 0; i < N_SRC; i++) begin : g_bit
      AST_FLAG_RISE_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag[i]) |-> $past(set_pulse[i])); // R4

      AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         set_pulse[i] |=> flag[i]); // R10

      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_we && reg_addr == SEL_FLAG && reg_wdata[i] && !set_pulse[i]) |=> !flag[i]); // R3

      AST_STATUS_WRITE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_we && reg_addr == SEL_STATUS && !set_pulse[i]) |=> flag[i] == $past(flag[i])); // R9

      AST_SET_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
         set_pulse[i] |=> !set_pulse[i]); // R6
   end

   AST_SMI_RISE_FROM_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(smi_o) |-> $past(|set_pulse)); // R11

endmodule

bind smi_flag_aggregator smi_flag_aggregator_chk #(
   .N_SRC(N_SRC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .flag     (flag_w),
   .set_pulse(set_w),
   .smi_o    (smi_o)
);

// File: tb/smi_flag_aggregator_test.sv
module smi_flag_aggregator_test;

   localparam logic [1:0] A_EN = 2'd0, A_FL = 2'd1, A_ST = 2'd2, A_NO = 2'd3;

   typedef struct packed {
      logic       is_rd;
      logic [1:0] addr;
      logic [7:0] data;
   } vec_t;

   // R2 / R3 register table: writes followed by read-compares
   localparam vec_t VEC [12] = '{
      '{1'b0, A_EN, 8'hA5}, '{1'b1, A_EN, 8'hA5},
      '{1'b0, A_EN, 8'h3C}, '{1'b1, A_EN, 8'h3C},
      '{1'b0, A_FL, 8'hFF}, '{1'b1, A_EN, 8'h3C},
      '{1'b1, A_FL, 8'h00}, '{1'b1, A_ST, 8'h00},
      '{1'b0, A_NO, 8'hFF}, '{1'b1, A_NO, 8'h00},
      '{1'b0, A_EN, 8'h00}, '{1'b1, A_EN, 8'h00}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] evt_i = '0;
   logic [7:0] nat_evt_i = '0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       smi_o;

   int nvec = 0;
   int nerr = 0;

   always #5 clk = ~clk;

   smi_flag_aggregator uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i),
      .nat_evt_i(nat_evt_i),
      .reg_we   (reg_we),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .smi_o    (smi_o)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_we    = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic short_pulse(input int idx);
      #2 evt_i[idx] = 1'b1;
      #1 evt_i[idx] = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd("R1 enables after reset", A_EN, 8'h00);
      rd("R1 flags after reset", A_FL, 8'h00);
      rd("R1 status after reset", A_ST, 8'h00);
      chk("R1 smi_o after reset", {7'b0, smi_o}, 8'h00);

      @(negedge clk);
      foreach (VEC[v]) begin
         if (VEC[v].is_rd) rd("R2 table read", VEC[v].addr, VEC[v].data);
         else wr(VEC[v].addr, VEC[v].data);
      end

      // R4 / R11: sub-cycle direct pulse while enabled
      @(negedge clk);
      wr(A_EN, 8'h02);
      short_pulse(1);
      repeat (5) @(negedge clk);
      rd("R4 direct pulse captured", A_FL, 8'h02);
      chk("R11 smi_o with one flag", {7'b0, smi_o}, 8'h01);
      wr(A_FL, 8'h00);
      rd("R3 write 0 keeps flag", A_FL, 8'h02);
      wr(A_FL, 8'h02);
      rd("R3 write 1 clears flag", A_FL, 8'h00);
      chk("R11 smi_o with no flags", {7'b0, smi_o}, 8'h00);

      // R5: pulse while disabled, then enable
      wr(A_EN, 8'h00);
      short_pulse(0);
      repeat (5) @(negedge clk);
      rd("R5 disabled pulse ignored", A_FL, 8'h00);
      wr(A_EN, 8'h01);
      repeat (5) @(negedge clk);
      rd("R5 no stale set on enable", A_FL, 8'h00);
      chk("R5 smi_o stays low", {7'b0, smi_o}, 8'h00);

      // R8 / R6 / R7 / R9: indirect source 7 via status bit 0
      wr(A_EN, 8'h80);
      nat_evt_i[0] = 1'b1;
      @(negedge clk);
      nat_evt_i[0] = 1'b0;
      repeat (2) @(negedge clk);
      rd("R8 status bit set", A_ST, 8'h01);
      rd("R8 summary sets source 7", A_FL, 8'h80);
      wr(A_FL, 8'h80);
      repeat (4) @(negedge clk);
      rd("R6 high summary no re-set", A_FL, 8'h00);
      wr(A_EN, 8'h00);
      wr(A_EN, 8'h80);
      repeat (2) @(negedge clk);
      rd("R7 enable toggle re-sets", A_FL, 8'h80);
      wr(A_ST, 8'h01);
      rd("R8 status write-1 clears", A_ST, 8'h00);
      rd("R9 status clear keeps flag", A_FL, 8'h80);
      wr(A_FL, 8'h80);

      // R8 mapping: status bit 5 reaches source 6 only
      wr(A_EN, 8'hC0);
      nat_evt_i[5] = 1'b1;
      @(negedge clk);
      nat_evt_i[5] = 1'b0;
      repeat (2) @(negedge clk);
      rd("R8 bit 5 maps to source 6", A_FL, 8'h40);
      rd("R8 status bit 5", A_ST, 8'h20);
      wr(A_FL, 8'hFF);
      wr(A_ST, 8'hFF);

      // R10: set edge and clear in the same cycle
      wr(A_EN, 8'h20);
      nat_evt_i[6] = 1'b1;
      @(negedge clk);
      nat_evt_i[6] = 1'b0;
      reg_we    = 1'b1;
      reg_addr  = A_FL;
      reg_wdata = 8'h20;
      @(negedge clk);
      reg_we = 1'b0;
      rd("R10 set wins over clear", A_FL, 8'h20);

      // R1: reset in mid-run
      wr(A_EN, 8'hFF);
      nat_evt_i[3] = 1'b1;
      @(negedge clk);
      nat_evt_i[3] = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      rd("R1 enables after mid reset", A_EN, 8'h00);
      rd("R1 flags after mid reset", A_FL, 8'h00);
      rd("R1 status after mid reset", A_ST, 8'h00);
      chk("R1 smi_o after mid reset", {7'b0, smi_o}, 8'h00);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

endmodule